// File: doc/BRIEF.md
# Level-Sensitive Dual-Output Interrupt Controller

This block collects a bank of 32 level-sensitive interrupt request lines into one cause word. It drives two processor interrupt outputs: a normal-priority line and a fast line. Each output has its own enable mask over the same cause word. A third mask word is kept as plain read/write storage and has no effect on either output. A system with more sources places several copies side by side, each behind its own register window.

Software reaches the block through a simple single-cycle register port with word-aligned byte offsets. The offsets are: cause at 0x00 (read only), normal mask at 0x04, fast mask at 0x08 and spare mask at 0x0C. The request lines are asynchronous to the block clock, so each one passes through two synchronizer flops before the cause register. A cause bit always follows its line. It cannot be set or cleared by software, so the handler services a source and then waits for that source to drop its line.

Top module: `lvl_intc`

## Requirements
- R1: After reset all three mask words read as zero, and both `irq_o` and `fiq_o` are low.
- R2: A read at offset 0x00 returns the cause word, in which bit i equals request line i. The line is delayed by two synchronizer flops and the cause flop, so the value is visible three clock edges after the line changes.
- R3: A write to offset 0x00 has no effect. The cause word keeps following the request lines.
- R4: `irq_o` is 1 exactly when some bit of (cause AND normal mask) is 1, registered one edge after the cause word and the masks.
- R5: `fiq_o` is 1 exactly when some bit of (cause AND fast mask) is 1, with the same one-edge timing as R4.
- R6: The normal mask (offset 0x04) and the fast mask (offset 0x08) are read/write. In each mask, bit value 1 enables the source and 0 disables it.
- R7: The spare mask at offset 0x0C is read/write storage. Its value changes neither output.
- R8: A read at any other offset, including an offset whose low two bits are not zero, returns zero. A write there changes no mask.
- R9: Writing zero to the normal mask disables all 32 sources. `irq_o` is low two edges after the write edge.
- R10: A cause bit is not latched. When its line drops, the bit returns to 0 and the outputs it drove fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive request lines, asynchronous |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read (valid with `sel_i`) |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as a read strobe, zero otherwise |
| irq_o | output | 1 | Normal-priority interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The hardest case to reach from the ports is a cause word that is active while every enable for it is off. In that state a source is pending but masked, and nothing outside shows it except a read of offset 0x00. The stimulus reaches it by holding lines high, clearing one or both masks, and filling the spare mask with ones. It then confirms that both outputs stay low while the cause still reads back the line levels. The timing around a mask write to zero is also pinned down: the output is sampled only after the mask register edge and the output register edge.

// File: rtl/lvl_intc_pkg.sv
`timescale 1ns/1ps
package lvl_intc_pkg;

    typedef enum logic [2:0] {
        SEL_CAUSE,
        SEL_IMASK,
        SEL_FMASK,
        SEL_EMASK,
        SEL_NONE
    } reg_sel_e;

    localparam logic [31:0] OFS_CAUSE = 32'h0000_0000;
    localparam logic [31:0] OFS_IMASK = 32'h0000_0004;
    localparam logic [31:0] OFS_FMASK = 32'h0000_0008;
    localparam logic [31:0] OFS_EMASK = 32'h0000_000C;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        reg_sel_e r;
        case (ofs)
            OFS_CAUSE: r = SEL_CAUSE;
            OFS_IMASK: r = SEL_IMASK;
            OFS_FMASK: r = SEL_FMASK;
            OFS_EMASK: r = SEL_EMASK;
            default:   r = SEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lvl_intc_sync.sv
`timescale 1ns/1ps
module lvl_intc_sync #(
    parameter int unsigned SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    output logic [SRC_W-1:0] cause_o
);

    typedef struct packed {
        logic [SRC_W-1:0] meta;
        logic [SRC_W-1:0] stab;
        logic [SRC_W-1:0] cause;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.meta  = src_i;
        s_d.stab  = s_q.meta;
        s_d.cause = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cause_o = s_q.cause;

    // R10: the cause word carries no memory of its own; it tracks the stable stage
    p_cause_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stab == '0) |=> (s_q.cause == '0));

endmodule

// File: rtl/lvl_intc_regs.sv
`timescale 1ns/1ps
module lvl_intc_regs
    import lvl_intc_pkg::*;
#(
    parameter int unsigned SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_i,
    input  reg_sel_e         rsel_i,
    input  logic [SRC_W-1:0] wdata_i,
    input  logic [SRC_W-1:0] cause_i,
    output logic [SRC_W-1:0] imask_o,
    output logic [SRC_W-1:0] fmask_o,
    output logic [SRC_W-1:0] rdata_o
);

    typedef struct packed {
        logic [SRC_W-1:0] imask;
        logic [SRC_W-1:0] fmask;
        logic [SRC_W-1:0] emask;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_en;

    assign wr_en = sel_i && wr_i;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (rsel_i)
                SEL_IMASK: r_d.imask = wdata_i;
                SEL_FMASK: r_d.fmask = wdata_i;
                SEL_EMASK: r_d.emask = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            case (rsel_i)
                SEL_CAUSE: rdata_o = cause_i;
                SEL_IMASK: rdata_o = r_q.imask;
                SEL_FMASK: rdata_o = r_q.fmask;
                SEL_EMASK: rdata_o = r_q.emask;
                default:   rdata_o = '0;
            endcase
        end
    end

    assign imask_o = r_q.imask;
    assign fmask_o = r_q.fmask;

    // R3: writing the cause offset leaves every stored word as it was
    p_cause_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel_i == SEL_CAUSE) |=> $stable(r_q));

    // R7: spare mask writes never touch the two enabling masks
    p_emask_iso_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel_i == SEL_EMASK) |=> ($stable(r_q.imask) && $stable(r_q.fmask)));

    // R8: writes at unmapped offsets are dropped
    p_unused_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel_i == SEL_NONE) |=> $stable(r_q));

    // R8: reads at unmapped offsets return zero
    p_unused_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && rsel_i == SEL_NONE) |-> (rdata_o == '0));

endmodule

// File: rtl/lvl_intc_outgen.sv
`timescale 1ns/1ps
module lvl_intc_outgen #(
    parameter int unsigned SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] cause_i,
    input  logic [SRC_W-1:0] imask_i,
    input  logic [SRC_W-1:0] fmask_i,
    output logic             irq_o,
    output logic             fiq_o
);

    typedef struct packed {
        logic irq;
        logic fiq;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(cause_i & imask_i);
        o_d.fiq = |(cause_i & fmask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_o = o_q.irq;
    assign fiq_o = o_q.fiq;

endmodule

// File: rtl/lvl_intc.sv
`timescale 1ns/1ps
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int unsigned SRC_W  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SRC_W-1:0]  wdata_i,
    output logic [SRC_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [31:0]      ofs_ext;
    reg_sel_e         rsel;
    logic [SRC_W-1:0] cause;
    logic [SRC_W-1:0] imask;
    logic [SRC_W-1:0] fmask;

    assign ofs_ext = 32'(addr_i);
    assign rsel    = decode_ofs(ofs_ext);

    lvl_intc_sync #(.SRC_W(SRC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .cause_o (cause)
    );

    lvl_intc_regs #(.SRC_W(SRC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .rsel_i  (rsel),
        .wdata_i (wdata_i),
        .cause_i (cause),
        .imask_o (imask),
        .fmask_o (fmask),
        .rdata_o (rdata_o)
    );

    lvl_intc_outgen #(.SRC_W(SRC_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .imask_i (imask),
        .fmask_i (fmask),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o)
    );

    // R4: normal output reflects the masked cause of the previous cycle
    p_irq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(cause & imask)));

    // R5: fast output reflects its own masked cause of the previous cycle
    p_fiq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == $past(|(cause & fmask)));

    // R9: a zero written to the normal mask silences the normal output two edges later
    p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && rsel == SEL_IMASK && wdata_i == '0) |=> ##1 !irq_o);

endmodule

// File: tb/lvl_intc_test.sv
`timescale 1ns/1ps
module lvl_intc_test;

    localparam int W  = 32;
    localparam int AW = 8;

    typedef struct packed {
        logic [W-1:0] src;
        logic [W-1:0] im;
        logic [W-1:0] fm;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TABLE [NVEC] = '{
        '{src: 32'h0000_0000, im: 32'hFFFF_FFFF, fm: 32'hFFFF_FFFF},
        '{src: 32'h0000_0001, im: 32'h0000_0001, fm: 32'h0000_0000},
        '{src: 32'h8000_0000, im: 32'h0000_0000, fm: 32'h8000_0000},
        '{src: 32'hA5A5_A5A5, im: 32'h5A5A_5A5A, fm: 32'h0000_FFFF},
        '{src: 32'hFFFF_FFFF, im: 32'h0001_0000, fm: 32'h0001_0000},
        '{src: 32'h00F0_0000, im: 32'h000F_0000, fm: 32'h0F00_0000},
        '{src: 32'h1234_5678, im: 32'h0000_0008, fm: 32'h1000_0000},
        '{src: 32'hDEAD_BEEF, im: 32'hFFFF_FFFF, fm: 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  src = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          irq;
    logic          fiq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lvl_intc #(.SRC_W(W), .ADDR_W(AW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .sel_i   (sel),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq),
        .fiq_o   (fiq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] rd;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state
        check("R1 irq", {31'b0, irq}, '0);
        check("R1 fiq", {31'b0, fiq}, '0);
        bus_read(8'h04, rd); check("R1 imask", rd, '0);
        bus_read(8'h08, rd); check("R1 fmask", rd, '0);
        bus_read(8'h0C, rd); check("R1 emask", rd, '0);

        // Table walk: R2, R4, R5, R6
        for (int k = 0; k < NVEC; k++) begin
            bus_write(8'h04, TABLE[k].im);
            bus_write(8'h08, TABLE[k].fm);
            src = TABLE[k].src;
            settle(6);
            check("R4 irq", {31'b0, irq}, {31'b0, |(TABLE[k].src & TABLE[k].im)});
            check("R5 fiq", {31'b0, fiq}, {31'b0, |(TABLE[k].src & TABLE[k].fm)});
            bus_read(8'h00, rd); check("R2 cause", rd, TABLE[k].src);
            bus_read(8'h04, rd); check("R6 imask", rd, TABLE[k].im);
            bus_read(8'h08, rd); check("R6 fmask", rd, TABLE[k].fm);
        end

        // R2: exact latency of three edges from line to cause
        src = 32'h0000_0000;
        settle(6);
        @(negedge clk);
        src = 32'h0000_0040;
        sel = 1'b1; wr = 1'b0; addr = 8'h00;
        @(negedge clk); @(negedge clk);
        #1 check("R2 latency early", rdata, 32'h0);
        @(negedge clk);
        #1 check("R2 latency on time", rdata, 32'h0000_0040);
        sel = 1'b0;

        // R3: cause write ignored
        src = 32'h0F0F_0F0F;
        settle(6);
        bus_write(8'h00, 32'hDEAD_BEEF);
        bus_read(8'h00, rd); check("R3 cause after write", rd, 32'h0F0F_0F0F);

        // R7: spare mask has no effect on outputs, masked-but-pending case
        bus_write(8'h04, 32'h0);
        bus_write(8'h08, 32'h0);
        src = 32'hFFFF_FFFF;
        bus_write(8'h0C, 32'hFFFF_FFFF);
        settle(6);
        check("R7 irq", {31'b0, irq}, '0);
        check("R7 fiq", {31'b0, fiq}, '0);
        bus_read(8'h0C, rd); check("R7 emask", rd, 32'hFFFF_FFFF);
        bus_read(8'h00, rd); check("R7 cause pending", rd, 32'hFFFF_FFFF);

        // R8: unmapped and unaligned offsets
        bus_read(8'h10, rd); check("R8 read 0x10", rd, '0);
        bus_read(8'h06, rd); check("R8 read 0x06", rd, '0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'hFFFF_FFFF);
        bus_write(8'h09, 32'hFFFF_FFFF);
        settle(3);
        check("R8 irq", {31'b0, irq}, '0);
        check("R8 fiq", {31'b0, fiq}, '0);
        bus_read(8'h04, rd); check("R8 imask kept", rd, '0);
        bus_read(8'h08, rd); check("R8 fmask kept", rd, '0);

        // R9: zero write disables everything, irq low two edges after write edge
        bus_write(8'h04, 32'hFFFF_FFFF);
        settle(2);
        check("R9 irq before", {31'b0, irq}, 32'h1);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 8'h04; wdata = 32'h0;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        check("R9 irq one edge", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R9 irq two edges", {31'b0, irq}, '0);

        // R10: no latching, output falls when line drops
        bus_write(8'h04, 32'h0000_0100);
        bus_write(8'h08, 32'h0000_0100);
        src = 32'h0000_0100;
        settle(6);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        check("R10 fiq raised", {31'b0, fiq}, 32'h1);
        src = 32'h0;
        settle(6);
        check("R10 irq fell", {31'b0, irq}, '0);
        check("R10 fiq fell", {31'b0, fiq}, '0);
        bus_read(8'h00, rd); check("R10 cause clear", rd, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule